// File: doc/BRIEF.md
# Segmented LRU Set Replacement

This block holds the replacement state of a single cache set with a configurable number of ways. The ways are split between two segments. A line that has just been filled sits in the probationary segment. A line that has been hit at least once sits in the protected segment. Each segment keeps its own order, from the line touched most recently to the line touched least recently. The protected segment has an upper size bound set at build time. When a hit would push the protected segment past that bound, its oldest line drops back to the newest position of the probationary segment. That line then gets a second chance to be reused before it can be evicted.

The surrounding cache controller does the tag compare. It reports every lookup on the access strobe, with a hit flag and the way that matched. It reads the victim way, and when the missed line returns it writes it into that way with the fill strobe. The block also reports which ways hold valid lines and which ways belong to the protected segment. Updates take effect on the clock edge after the strobe, and the victim output is derived from registered state only.

Top module: `slru_set_repl`

## Requirements
- R1: While reset is high, at the clock edge every way becomes invalid and neither segment holds any line. After reset, the valid vector is all zeros, the protected vector is all zeros and the victim is way 0.
- R2: While at least one way is invalid, the victim output is the lowest-numbered invalid way.
- R3: A fill with no access hit in the same cycle makes the filled way valid. From the next cycle the way is a member of the probationary segment (its bit in `way_prot_o` is 0), in the most recently used position of that segment.
- R4: An access with the hit flag set, on a way that holds a valid probationary line, moves that line to the most recently used position of the protected segment from the next cycle. The probationary lines that stood ahead of it keep their relative order.
- R5: If a promotion under R4 finds the protected segment already holding PROT_MAX lines, the least recently used protected line moves in the same cycle to the most recently used position of the probationary segment.
- R6: When every way is valid, the victim is the least recently used line of the probationary segment. It is never a protected line.
- R7: A hit on a protected line moves it to the most recently used position of the protected segment. A hit on the line that already holds that position leaves every order unchanged.
- R8: An access with the hit flag low, or a hit on a way that is invalid, changes no state.
- R9: When the access strobe with the hit flag and the fill strobe are both high in one cycle, the hit is processed and the fill is ignored.
- R10: The protected segment never holds more than PROT_MAX lines.
- R11: A fill into a way that already holds a line takes that line out of its current segment. The segment closes the gap, and the way is then placed as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| acc_vld_i | input | 1 | A lookup of this set occurred this cycle |
| acc_hit_i | input | 1 | The lookup matched a line |
| acc_way_i | input | $clog2(NUM_WAYS) | Way that matched |
| fill_vld_i | input | 1 | A line is written into the set this cycle |
| fill_way_i | input | $clog2(NUM_WAYS) | Way receiving the line |
| victim_way_o | output | $clog2(NUM_WAYS) | Way to replace on the next miss |
| way_valid_o | output | NUM_WAYS | One bit per way: holds a line |
| way_prot_o | output | NUM_WAYS | One bit per way: line is in the protected segment |

## Verification
The case of most interest is a hit on a probationary line while the protected segment is full. In that one cycle a promotion and a demotion happen together, and both segment orders move. The bench first fills the protected segment with hits, then hits a further probationary line. A list model of the two segments in the bench predicts the demoted way, the new probationary order and the victim that follows. A long pseudo-random sweep on four ways with a bound of two repeats this collision many times, together with simultaneous hit and fill strobes, and compares the victim and both membership vectors after every step.

// File: rtl/slru_pkg.sv
package slru_pkg;

    // operation applied to the set in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2
    } slru_op_e;

endpackage

// File: rtl/slru_way_next.sv
// Next-state logic for one way: validity, segment and rank inside its segment.
// Rank 0 is the most recently used position of the segment.
module slru_way_next
    import slru_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int PROT_MAX = 2,
    parameter int WAY_IDX  = 0,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  slru_op_e             op_i,
    input  logic [WAY_W-1:0]     tgt_way_i,
    input  logic                 tgt_valid_i,
    input  logic                 tgt_prot_i,
    input  logic [WAY_W-1:0]     tgt_rank_i,
    input  logic                 demote_i,
    input  logic                 cur_valid_i,
    input  logic                 cur_prot_i,
    input  logic [WAY_W-1:0]     cur_rank_i,
    output logic                 nxt_valid_o,
    output logic                 nxt_prot_o,
    output logic [WAY_W-1:0]     nxt_rank_o
);

    localparam logic [WAY_W-1:0] PROT_LAST = WAY_W'(PROT_MAX - 1);
    localparam logic [WAY_W-1:0] SELF      = WAY_W'(WAY_IDX);

    logic is_self;
    logic ahead_of_tgt;
    logic behind_tgt;

    always_comb begin
        is_self      = (tgt_way_i == SELF);
        ahead_of_tgt = (cur_rank_i < tgt_rank_i);
        behind_tgt   = (cur_rank_i > tgt_rank_i);
    end

    always_comb begin
        nxt_valid_o = cur_valid_i;
        nxt_prot_o  = cur_prot_i;
        nxt_rank_o  = cur_rank_i;
        unique case (op_i)
            OP_HIT: begin
                if (is_self) begin
                    nxt_valid_o = 1'b1;
                    nxt_prot_o  = 1'b1;
                    nxt_rank_o  = '0;
                end else if (cur_valid_i) begin
                    if (tgt_prot_i) begin
                        // reorder within the protected segment only
                        if (cur_prot_i && ahead_of_tgt) begin
                            nxt_rank_o = cur_rank_i + 1'b1;
                        end
                    end else if (cur_prot_i) begin
                        if (demote_i && cur_rank_i == PROT_LAST) begin
                            nxt_prot_o = 1'b0;
                            nxt_rank_o = '0;
                        end else begin
                            nxt_rank_o = cur_rank_i + 1'b1;
                        end
                    end else begin
                        // probationary line, target leaves this segment
                        if (demote_i) begin
                            if (ahead_of_tgt) begin
                                nxt_rank_o = cur_rank_i + 1'b1;
                            end
                        end else if (behind_tgt) begin
                            nxt_rank_o = cur_rank_i - 1'b1;
                        end
                    end
                end
            end
            OP_FILL: begin
                if (is_self) begin
                    nxt_valid_o = 1'b1;
                    nxt_prot_o  = 1'b0;
                    nxt_rank_o  = '0;
                end else if (cur_valid_i) begin
                    if (!tgt_valid_i) begin
                        if (!cur_prot_i) begin
                            nxt_rank_o = cur_rank_i + 1'b1;
                        end
                    end else if (tgt_prot_i) begin
                        if (!cur_prot_i) begin
                            nxt_rank_o = cur_rank_i + 1'b1;
                        end else if (behind_tgt) begin
                            nxt_rank_o = cur_rank_i - 1'b1;
                        end
                    end else begin
                        if (!cur_prot_i && ahead_of_tgt) begin
                            nxt_rank_o = cur_rank_i + 1'b1;
                        end
                    end
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/slru_victim_sel.sv
// Chooses the way to replace: lowest invalid way, else probationary LRU.
module slru_victim_sel #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic [NUM_WAYS-1:0]            valid_i,
    input  logic [NUM_WAYS-1:0]            prot_i,
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] rank_i,
    input  logic [CNT_W-1:0]               prob_cnt_i,
    output logic [WAY_W-1:0]               victim_o
);

    logic             any_invalid;
    logic [CNT_W-1:0] lru_pos;

    always_comb begin
        any_invalid = ~&valid_i;
        lru_pos     = prob_cnt_i - 1'b1;
        victim_o    = '0;
        if (any_invalid) begin
            for (int i = NUM_WAYS - 1; i >= 0; i--) begin
                if (!valid_i[i]) begin
                    victim_o = WAY_W'(i);
                end
            end
        end else begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                if (!prot_i[i] && CNT_W'(rank_i[i]) == lru_pos) begin
                    victim_o = WAY_W'(i);
                end
            end
        end
    end

    assert_victim_invalid_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (~&valid_i) |-> !valid_i[victim_o]);

    assert_victim_prob_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (&valid_i) |-> !prot_i[victim_o]);

endmodule

// File: rtl/slru_set_repl.sv
// Segmented LRU replacement state for one cache set.
module slru_set_repl
    import slru_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int PROT_MAX = 2,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                acc_vld_i,
    input  logic                acc_hit_i,
    input  logic [WAY_W-1:0]    acc_way_i,
    input  logic                fill_vld_i,
    input  logic [WAY_W-1:0]    fill_way_i,
    output logic [WAY_W-1:0]    victim_way_o,
    output logic [NUM_WAYS-1:0] way_valid_o,
    output logic [NUM_WAYS-1:0] way_prot_o
);

    typedef struct packed {
        logic [NUM_WAYS-1:0]            valid;
        logic [NUM_WAYS-1:0]            prot;
        logic [NUM_WAYS-1:0][WAY_W-1:0] rank;
    } set_state_t;

    set_state_t state_d, state_q;

    slru_op_e         op;
    logic [WAY_W-1:0] tgt_way;
    logic             hit_req;
    logic [CNT_W-1:0] prot_cnt, prob_cnt;
    logic             demote;

    logic [NUM_WAYS-1:0]            nxt_valid;
    logic [NUM_WAYS-1:0]            nxt_prot;
    logic [NUM_WAYS-1:0][WAY_W-1:0] nxt_rank;

    // segment occupancy
    always_comb begin
        prot_cnt = '0;
        prob_cnt = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (state_q.valid[i]) begin
                if (state_q.prot[i]) prot_cnt = prot_cnt + 1'b1;
                else                 prob_cnt = prob_cnt + 1'b1;
            end
        end
    end

    // operation decode: a hit strobe outranks a fill
    always_comb begin
        hit_req = acc_vld_i && acc_hit_i;
        op      = OP_IDLE;
        tgt_way = fill_way_i;
        if (hit_req) begin
            tgt_way = acc_way_i;
            if (state_q.valid[acc_way_i]) op = OP_HIT;
        end else if (fill_vld_i) begin
            op = OP_FILL;
        end
        demote = (op == OP_HIT) && !state_q.prot[tgt_way]
                 && (prot_cnt == CNT_W'(PROT_MAX));
    end

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        slru_way_next #(
            .NUM_WAYS (NUM_WAYS),
            .PROT_MAX (PROT_MAX),
            .WAY_IDX  (g)
        ) u_way (
            .op_i        (op),
            .tgt_way_i   (tgt_way),
            .tgt_valid_i (state_q.valid[tgt_way]),
            .tgt_prot_i  (state_q.prot[tgt_way]),
            .tgt_rank_i  (state_q.rank[tgt_way]),
            .demote_i    (demote),
            .cur_valid_i (state_q.valid[g]),
            .cur_prot_i  (state_q.prot[g]),
            .cur_rank_i  (state_q.rank[g]),
            .nxt_valid_o (nxt_valid[g]),
            .nxt_prot_o  (nxt_prot[g]),
            .nxt_rank_o  (nxt_rank[g])
        );
    end

    always_comb begin
        state_d.valid = nxt_valid;
        state_d.prot  = nxt_prot;
        state_d.rank  = nxt_rank;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    slru_victim_sel #(
        .NUM_WAYS (NUM_WAYS)
    ) u_victim (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .valid_i    (state_q.valid),
        .prot_i     (state_q.prot),
        .rank_i     (state_q.rank),
        .prob_cnt_i (prob_cnt),
        .victim_o   (victim_way_o)
    );

    always_comb begin
        way_valid_o = state_q.valid;
        way_prot_o  = state_q.prot & state_q.valid;
    end

    assert_prot_bound_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(way_prot_o) <= PROT_MAX);

    assert_promote_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_vld_i && acc_hit_i && way_valid_o[acc_way_i])
        |=> way_prot_o[$past(acc_way_i)]);

    assert_fill_prob_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_vld_i && !(acc_vld_i && acc_hit_i))
        |=> (way_valid_o[$past(fill_way_i)] && !way_prot_o[$past(fill_way_i)]));

    assert_fill_yields_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_vld_i && acc_hit_i && fill_vld_i && fill_way_i != acc_way_i
         && !way_valid_o[fill_way_i])
        |=> !way_valid_o[$past(fill_way_i)]);

    assert_miss_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_vld_i && !acc_hit_i && !fill_vld_i)
        |=> ($stable(way_valid_o) && $stable(way_prot_o) && $stable(victim_way_o)));

endmodule

// File: tb/slru_set_repl_bench.sv
module slru_set_repl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int PM = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_vld, acc_hit, fill_vld;
    logic [1:0] acc_way, fill_way;
    logic [1:0] victim;
    logic [3:0] vvec, pvec;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // list model: index 0 is the most recently used entry
    int prot_l[NW];
    int prob_l[NW];
    int prot_n;
    int prob_n;
    bit mv[NW];

    always #(CLK_PERIOD / 2) clk = ~clk;

    slru_set_repl #(.NUM_WAYS(NW), .PROT_MAX(PM)) u_slru_set_repl (
        .clk_i        (clk),
        .rst_i        (rst),
        .acc_vld_i    (acc_vld),
        .acc_hit_i    (acc_hit),
        .acc_way_i    (acc_way),
        .fill_vld_i   (fill_vld),
        .fill_way_i   (fill_way),
        .victim_way_o (victim),
        .way_valid_o  (vvec),
        .way_prot_o   (pvec)
    );

    function automatic void m_reset();
        prot_n = 0;
        prob_n = 0;
        for (int k = 0; k < NW; k++) mv[k] = 1'b0;
    endfunction

    function automatic void m_remove(int w);
        for (int k = 0; k < prot_n; k++) begin
            if (prot_l[k] == w) begin
                for (int j = k; j < prot_n - 1; j++) prot_l[j] = prot_l[j+1];
                prot_n--;
                return;
            end
        end
        for (int k = 0; k < prob_n; k++) begin
            if (prob_l[k] == w) begin
                for (int j = k; j < prob_n - 1; j++) prob_l[j] = prob_l[j+1];
                prob_n--;
                return;
            end
        end
    endfunction

    function automatic void m_push_prob(int w);
        for (int j = prob_n; j > 0; j--) prob_l[j] = prob_l[j-1];
        prob_l[0] = w;
        prob_n++;
    endfunction

    function automatic void m_hit(int w);
        if (!mv[w]) return;
        m_remove(w);
        if (prot_n == PM) begin
            prot_n--;
            m_push_prob(prot_l[prot_n]);
        end
        for (int j = prot_n; j > 0; j--) prot_l[j] = prot_l[j-1];
        prot_l[0] = w;
        prot_n++;
    endfunction

    function automatic void m_fill(int w);
        if (mv[w]) m_remove(w);
        mv[w] = 1'b1;
        m_push_prob(w);
    endfunction

    function automatic int exp_victim();
        for (int k = 0; k < NW; k++) if (!mv[k]) return k;
        return prob_l[prob_n-1];
    endfunction

    function automatic logic [3:0] exp_valid();
        logic [3:0] v;
        for (int k = 0; k < NW; k++) v[k] = mv[k];
        return v;
    endfunction

    function automatic logic [3:0] exp_prot();
        logic [3:0] p = '0;
        for (int k = 0; k < prot_n; k++) p[prot_l[k]] = 1'b1;
        return p;
    endfunction

    task automatic check_state(input string tag);
        checks++;
        if (victim !== 2'(exp_victim()) || vvec !== exp_valid() || pvec !== exp_prot()) begin
            failures++;
            $display("FAIL %s victim=%0d exp=%0d valid=%b exp=%b prot=%b exp=%b",
                     tag, victim, exp_victim(), vvec, exp_valid(), pvec, exp_prot());
        end
    endtask

    task automatic step(input logic av, input logic ah, input int aw,
                        input logic fv, input int fw, input string tag);
        @(negedge clk);
        acc_vld  = av;
        acc_hit  = ah;
        acc_way  = 2'(aw);
        fill_vld = fv;
        fill_way = 2'(fw);
        if (av && ah)  m_hit(aw);
        else if (fv)   m_fill(fw);
        @(posedge clk);
        #1;
        acc_vld  = 1'b0;
        fill_vld = 1'b0;
        check_state(tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        rst = 1'b1;
        acc_vld = 1'b0; acc_hit = 1'b0; acc_way = '0;
        fill_vld = 1'b0; fill_way = '0;
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        check_state("R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R8: hit on an invalid way and a missing lookup do nothing
        step(1, 1, 1, 0, 0, "R8 hit invalid way");
        step(1, 0, 0, 0, 0, "R8 miss lookup");
        // R2: out of order fill, victim stays lowest invalid
        step(0, 0, 0, 1, 2, "R2 lowest invalid");
        step(0, 0, 0, 1, 0, "R2 lowest invalid after way0");
        step(0, 0, 0, 1, 1, "R3 fill to probation");
        step(0, 0, 0, 1, 3, "R6 all valid, probation LRU");
        // R4: promote way 2 and way 3
        step(1, 1, 2, 0, 0, "R4 promote");
        step(1, 1, 3, 0, 0, "R4 promote second");
        // R5: protected full, promoting way 0 demotes way 2
        step(1, 1, 0, 0, 0, "R5 promote with demotion");
        // R7: hit protected LRU, then hit protected MRU
        step(1, 1, 3, 0, 0, "R7 protected reorder");
        step(1, 1, 3, 0, 0, "R7 protected MRU unchanged");
        // R9: hit and fill in one cycle
        step(1, 1, 1, 1, 2, "R9 hit beats fill");
        // R11: refill of a protected way
        step(0, 0, 0, 1, 3, "R11 refill protected way");
        step(0, 0, 0, 1, 2, "R11 refill probation way");
        step(0, 0, 0, 1, exp_victim(), "R6 fill victim");

        // pseudo-random sweep over all operation mixes
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[1:0])
                2'd0: step(1, 1, int'(lf[3:2]), 0, 0, "R4 R5 R7 sweep hit");
                2'd1: step(0, 0, 0, 1, exp_victim(), "R6 R10 sweep fill victim");
                2'd2: step(0, 0, 0, 1, int'(lf[5:4]), "R11 sweep fill any");
                default: step(1, lf[6], int'(lf[3:2]), lf[7], int'(lf[5:4]),
                              "R9 R8 sweep mixed");
            endcase
            if (lf[15:9] == 7'h00) begin
                @(negedge clk);
                rst = 1'b1;
                m_reset();
                @(posedge clk);
                #1;
                check_state("R1 reset mid run");
                @(negedge clk);
                rst = 1'b0;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule